// File: doc/BRIEF.md
# Exception Pending Control Register

This block is one 32-bit memory-mapped control and status word for a small interrupt controller. It stores the pending state of three system exceptions: a non-maskable interrupt (index 0), a deferred-service exception (index 1) and a system-timer exception (index 2). Software makes an exception pending by writing 1 to its set bit. For the deferred-service and timer exceptions, software removes the pending state by writing 1 to a separate clear bit. Writing 0 to any bit does nothing.

Hardware sources drive a per-exception set strobe. The core drives a per-exception acknowledge strobe when it takes an exception. For the non-maskable interrupt, that acknowledge marks entry into the handler. If the request arrives again during the handler, the pending bit sets again.

The word also shows core-supplied status as read-only fields: the active and pending vector numbers, a preempted flag, an any-pending flag and a return-to-base flag. The three pending bits leave the block as level signals for the priority logic.

The bus is a plain single-cycle interface with no handshake and no back-pressure. A write with `bus_sel` and `bus_wr` high to address `REG_OFFSET` takes effect at the next rising clock edge. A read is combinational: with `bus_sel` high, `bus_wr` low and the address matching, `bus_rdata` shows the word, and otherwise it is 0.

Top module: `exc_pend_ctl`

## Requirements
- R1: After reset is asserted (`rst_n` low), all pending bits are 0. With all status inputs at 0, a read returns 32'h0000_0000.
- R2: A write of 1 to bit 31 (non-maskable), bit 28 (deferred-service) or bit 26 (timer) makes that exception pending from the next clock edge. A read returns each pending state at the same bit. Writing 0 to those bits leaves them unchanged.
- R3: A write of 1 to bit 27 clears the deferred-service pending state, and a write of 1 to bit 25 clears the timer pending state. Both bits always read as 0.
- R4: When the set bit and the clear bit of one exception are both 1 in a single write, and no hardware set for it arrives in that cycle, the exception ends not pending.
- R5: Bits 30, 29 and 24 are reserved. The unused bits 21–20 and 10–8 read as 0. Writes to any of these bits, and to the read-only fields, change no state.
- R6: On a read, bit 23 equals `core_preempt`, bit 22 equals `core_any_pend`, bits 19–12 equal `core_pend_vec`, bit 11 equals `core_ret_base` and bits 7–0 equal `core_act_vec`, all in the same cycle.
- R7: `hw_set[k]` makes exception k pending from the next edge. `ack[k]` clears it at the next edge. When both arrive in the same cycle, the exception ends pending.
- R8: `ack[0]` (non-maskable handler entry) clears the non-maskable pending bit. A later `hw_set[0]` during the handler sets it again, and it reads back as 1.
- R9: A write with `bus_sel` low, or to an address other than `REG_OFFSET`, changes no state. A read of another address returns 0.
- R10: The `pend` output always equals the three pending bits that a read returns (bit 31 maps to `pend[0]`, bit 28 to `pend[1]` and bit 26 to `pend[2]`).
- R11: A hardware set and a software clear of the same exception in one cycle leave the exception pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 selects a write, 0 a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when not reading this word |
| hw_set | input | 3 | Hardware set strobes, one per exception |
| ack | input | 3 | Exception-taken strobes from the core |
| core_preempt | input | 1 | Preempted-interrupt status |
| core_any_pend | input | 1 | Any-interrupt-pending status |
| core_pend_vec | input | 8 | Highest pending vector number |
| core_ret_base | input | 1 | Return-to-base status |
| core_act_vec | input | 8 | Active vector number |
| pend | output | 3 | Pending levels: 0 non-maskable, 1 deferred-service, 2 timer |

## Verification
The assertions check on every cycle that a hardware set always wins and that an acknowledge or a clear write takes effect one edge later. They also check that state holds when no write or strobe is present, that reserved and write-only bits read 0, and that `pend` agrees with the read-back bits. Only the bench's scenarios can show some behaviours. These are the ordered state that a sequence of writes builds up, the non-maskable clear-then-reassert sequence, and the pass-through of particular status values. They also include the absence of effect from writes to another address or with select low, and reset in the middle of a run.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  localparam int NUM_EXC = 3;
  localparam int WORD_W  = 32;
  localparam int VEC_W   = 8;

  localparam int IDX_NMI = 0;
  localparam int IDX_DSV = 1;
  localparam int IDX_TMR = 2;

  localparam int POS_PREEMPT = 23;
  localparam int POS_ANYPEND = 22;
  localparam int POS_PVEC_LO = 12;
  localparam int POS_RETBASE = 11;
  localparam int POS_AVEC_LO = 0;

  function automatic int set_pos(input int k);
    case (k)
      IDX_NMI: set_pos = 31;
      IDX_DSV: set_pos = 28;
      default: set_pos = 26;
    endcase
  endfunction

  function automatic bit has_clr(input int k);
    has_clr = (k != IDX_NMI);
  endfunction

  function automatic int clr_pos(input int k);
    case (k)
      IDX_DSV: clr_pos = 27;
      default: clr_pos = 25;
    endcase
  endfunction
endpackage

// File: rtl/exc_pend_decode.sv
module exc_pend_decode
  import exc_pend_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0C0
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              rd_hit,
  output logic [NUM_EXC-1:0] sw_set,
  output logic [NUM_EXC-1:0] sw_clr
);
  logic addr_hit;
  logic wr_hit;

  assign addr_hit = (bus_addr == REG_OFFSET);
  assign wr_hit   = bus_sel & bus_wr & addr_hit;
  assign rd_hit   = bus_sel & ~bus_wr & addr_hit;

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_exc
    assign sw_set[k] = wr_hit & bus_wdata[set_pos(k)];
    if (has_clr(k)) begin : g_clr
      assign sw_clr[k] = wr_hit & bus_wdata[clr_pos(k)];
    end else begin : g_noclr
      assign sw_clr[k] = 1'b0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/exc_pend_bit.sv
module exc_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  input  logic ack,
  output logic pend_q
);
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (ack || sw_clr)       pend_d = 1'b0;
    if (sw_set && !sw_clr)   pend_d = 1'b1;
    if (hw_set)              pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/exc_pend_rdmux.sv
module exc_pend_rdmux
  import exc_pend_pkg::*;
(
  input  logic               rd_hit,
  input  logic [NUM_EXC-1:0] pend,
  input  logic               core_preempt,
  input  logic               core_any_pend,
  input  logic [VEC_W-1:0]   core_pend_vec,
  input  logic               core_ret_base,
  input  logic [VEC_W-1:0]   core_act_vec,
  output logic [WORD_W-1:0]  rdata
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_EXC; k++) word[set_pos(k)] = pend[k];
    word[POS_PREEMPT] = core_preempt;
    word[POS_ANYPEND] = core_any_pend;
    word[POS_PVEC_LO +: VEC_W] = core_pend_vec;
    word[POS_RETBASE] = core_ret_base;
    word[POS_AVEC_LO +: VEC_W] = core_act_vec;
  end

  assign rdata = rd_hit ? word : '0;
endmodule

// File: rtl/exc_pend_ctl.sv
module exc_pend_ctl
  import exc_pend_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [2:0]        hw_set,
  input  logic [2:0]        ack,
  input  logic              core_preempt,
  input  logic              core_any_pend,
  input  logic [7:0]        core_pend_vec,
  input  logic              core_ret_base,
  input  logic [7:0]        core_act_vec,
  output logic [2:0]        pend
);
  logic               rd_hit;
  logic [NUM_EXC-1:0] sw_set;
  logic [NUM_EXC-1:0] sw_clr;

  exc_pend_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_hit(rd_hit), .sw_set(sw_set), .sw_clr(sw_clr)
  );

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_cell
    exc_pend_bit u_bit (
      .clk(clk), .rst_n(rst_n), .sw_set(sw_set[k]), .sw_clr(sw_clr[k]),
      .hw_set(hw_set[k]), .ack(ack[k]), .pend_q(pend[k])
    );
  end

  exc_pend_rdmux u_rd (
    .rd_hit(rd_hit), .pend(pend), .core_preempt(core_preempt),
    .core_any_pend(core_any_pend), .core_pend_vec(core_pend_vec),
    .core_ret_base(core_ret_base), .core_act_vec(core_act_vec),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/exc_pend_chk.sv
module exc_pend_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [2:0]        hw_set,
  input logic [2:0]        ack,
  input logic [2:0]        pend
);
  logic wr_here;
  logic rd_here;
  assign wr_here = bus_sel & bus_wr & (bus_addr == REG_OFFSET);
  assign rd_here = bus_sel & ~bus_wr & (bus_addr == REG_OFFSET);

  assert_set_dsv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && bus_wdata[28] && !bus_wdata[27]) |=> pend[1]);

  assert_clr_tmr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && bus_wdata[25] && !hw_set[2]) |=> !pend[2]);

  assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && bus_wdata[28] && bus_wdata[27] && !hw_set[1]) |=> !pend[1]);

  assert_zero_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_here |-> (bus_rdata[30:29] == 2'b00 && bus_rdata[27] == 1'b0 &&
                 bus_rdata[25:24] == 2'b00 && bus_rdata[21:20] == 2'b00 &&
                 bus_rdata[10:8] == 3'b000));

  assert_hw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((pend & $past(hw_set)) == $past(hw_set)));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[2] && !hw_set[2] && !wr_here) |=> !pend[2]);

  assert_nmi_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !hw_set[0] && !(wr_here && bus_wdata[31])) |=> !pend[0]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_here && hw_set == 3'b000 && ack == 3'b000) |=> $stable(pend));

  assert_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_here |-> (bus_rdata[31] == pend[0] && bus_rdata[28] == pend[1] &&
                 bus_rdata[26] == pend[2]));

  assert_none_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_here |-> (bus_rdata == 32'h0));

  logic unused_chk;
  assign unused_chk = ^bus_wdata;
endmodule

bind exc_pend_ctl exc_pend_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .hw_set(hw_set), .ack(ack), .pend(pend)
);

// File: tb/exc_pend_ctl_tb.sv
module exc_pend_ctl_tb;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF = 12'h0C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] hw_set = '0, ack = '0;
  logic core_preempt = 1'b0, core_any_pend = 1'b0, core_ret_base = 1'b0;
  logic [7:0] core_pend_vec = '0, core_act_vec = '0;
  logic [2:0] pend;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  exc_pend_ctl #(.ADDR_W(ADDR_W), .REG_OFFSET(OFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_set(hw_set), .ack(ack), .core_preempt(core_preempt),
    .core_any_pend(core_any_pend), .core_pend_vec(core_pend_vec),
    .core_ret_base(core_ret_base), .core_act_vec(core_act_vec), .pend(pend)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic [2:0]  hw;
    logic [2:0]  ak;
    logic [2:0]  ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1, 32'h8000_0000, 3'b000, 3'b000, 3'b001, 4'd2},  // R2 set nmi
    '{1'b1, 32'h0000_0000, 3'b000, 3'b000, 3'b001, 4'd2},  // R2 zero write
    '{1'b1, 32'h1000_0000, 3'b000, 3'b000, 3'b011, 4'd2},  // R2 set dsv
    '{1'b1, 32'h0400_0000, 3'b000, 3'b000, 3'b111, 4'd2},  // R2 set tmr
    '{1'b1, 32'h0800_0000, 3'b000, 3'b000, 3'b101, 4'd3},  // R3 clr dsv
    '{1'b1, 32'h0200_0000, 3'b000, 3'b000, 3'b001, 4'd3},  // R3 clr tmr
    '{1'b1, 32'h1800_0000, 3'b000, 3'b000, 3'b001, 4'd4},  // R4 dsv both
    '{1'b1, 32'h0600_0000, 3'b000, 3'b000, 3'b001, 4'd4},  // R4 tmr both
    '{1'b0, 32'h0000_0000, 3'b000, 3'b001, 3'b000, 4'd8},  // R8 entry
    '{1'b0, 32'h0000_0000, 3'b001, 3'b000, 3'b001, 4'd8},  // R8 reassert
    '{1'b0, 32'h0000_0000, 3'b110, 3'b000, 3'b111, 4'd7},  // R7 hw set
    '{1'b0, 32'h0000_0000, 3'b010, 3'b010, 3'b111, 4'd7},  // R7 set wins
    '{1'b0, 32'h0000_0000, 3'b000, 3'b110, 3'b001, 4'd7},  // R7 ack
    '{1'b1, 32'h0200_0000, 3'b100, 3'b000, 3'b101, 4'd11}, // R11
    '{1'b1, 32'h6100_0000, 3'b000, 3'b000, 3'b101, 4'd5},  // R5 reserved
    '{1'b0, 32'h0000_0000, 3'b000, 3'b101, 3'b000, 4'd7}   // R7 ack two
  };

  function automatic logic [31:0] exp_word(input logic [2:0] p, input logic pre,
      input logic any, input logic [7:0] pv, input logic rb, input logic [7:0] av);
    logic [31:0] w;
    w = '0;
    w[31] = p[0]; w[28] = p[1]; w[26] = p[2];
    w[23] = pre; w[22] = any; w[19:12] = pv; w[11] = rb; w[7:0] = av;
    return w;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [ADDR_W-1:0] a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    #1;
  endtask

  task automatic step(input logic sel, input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [31:0] wd, input logic [2:0] h, input logic [2:0] k);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; hw_set = h; ack = k;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; hw_set = '0; ack = '0;
    read_at(OFF);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    read_at(OFF);
    check32("R1 reset rdata", bus_rdata, 32'h0);
    check32("R1 reset pend", {29'd0, pend}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VT[i].wr, VT[i].wr, OFF, VT[i].wd, VT[i].hw, VT[i].ak);
      check32($sformatf("R%0d vec %0d pend", VT[i].req, i), {29'd0, pend}, {29'd0, VT[i].ex});
      check32($sformatf("R%0d vec %0d rdata (R10)", VT[i].req, i), bus_rdata,
              exp_word(VT[i].ex, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00));
    end

    // R6 status pass-through, two patterns
    core_preempt = 1'b1; core_any_pend = 1'b0; core_pend_vec = 8'hA5;
    core_ret_base = 1'b1; core_act_vec = 8'h3C;
    read_at(OFF);
    check32("R6 status A", bus_rdata, exp_word(3'b000, 1'b1, 1'b0, 8'hA5, 1'b1, 8'h3C));
    core_preempt = 1'b0; core_any_pend = 1'b1; core_pend_vec = 8'h5A;
    core_ret_base = 1'b0; core_act_vec = 8'hC3;
    read_at(OFF);
    check32("R6 status B", bus_rdata, exp_word(3'b000, 1'b0, 1'b1, 8'h5A, 1'b0, 8'hC3));
    core_any_pend = 1'b0; core_pend_vec = 8'h00; core_act_vec = 8'h00;

    // R5 writes to read-only fields change no state
    step(1'b1, 1'b1, OFF, 32'h00FF_FFFF, 3'b000, 3'b000);
    check32("R5 readonly write", bus_rdata, 32'h0);

    // R9 wrong address and select low
    step(1'b1, 1'b1, OFF + 12'h004, 32'h9400_0000, 3'b000, 3'b000);
    check32("R9 other addr write", bus_rdata, 32'h0);
    step(1'b0, 1'b1, OFF, 32'h9400_0000, 3'b000, 3'b000);
    check32("R9 sel low write", bus_rdata, 32'h0);
    step(1'b1, 1'b1, OFF, 32'h9400_0000, 3'b000, 3'b000);
    read_at(OFF + 12'h004);
    check32("R9 other addr read", bus_rdata, 32'h0);
    read_at(OFF);
    check32("R2 all set", bus_rdata, exp_word(3'b111, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00));

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    read_at(OFF);
    check32("R1 mid-run reset", {29'd0, pend}, 32'h0);
    rst_n = 1'b1;

    finish_run();
  end
endmodule